// File: doc/BRIEF.md
# Early Transmit Threshold Gate

The gate sits between a transmit byte FIFO and the line-side MAC. It decides when the MAC may start draining the packet that is being loaded. A descriptor hands over a 6-bit threshold code and a packet length. The gate turns the code into a byte count and compares that count with the FIFO occupancy. It grants start permission when the occupancy reaches the threshold, or earlier if every byte of the packet has already been written.

Once permission is granted it holds until the MAC marks end of packet. While the packet drains, the gate watches for the FIFO running dry before the last byte has left. If that happens it records an underrun but does not abort. The MAC keeps taking bytes as they arrive, and the outcome reported at end of packet is "underrun" rather than "good".

Top module: `tx_early_gate`

## Requirements
- R1: After reset, tx_start, pkt_loaded and done_valid are 0.
- R2: Threshold code 0 means 8 bytes. With code 0 and an incomplete packet, tx_start stays 0 while fifo_cnt is 7, and is 1 one cycle after fifo_cnt is 8 at a clock edge.
- R3: A threshold code n from 1 to 63 means n×32 bytes. For code 2 the permission needs fifo_cnt ≥ 64, and 63 is not enough.
- R4: A decoded threshold above the FIFO capacity FIFO_BYTES is clamped to FIFO_BYTES. With a 512-byte FIFO, code 63 grants at an occupancy of 512 and not at 511.
- R5: Permission is also granted, one cycle later, once the whole packet has been written, even when the occupancy is below the threshold.
- R6: Once tx_start is 1 it stays 1 until mac_eop, even if fifo_cnt falls below the threshold.
- R7: The threshold and length are captured on an accepted pkt_begin. Later changes on thr_code and pkt_len do not affect the packet in flight.
- R8: At end of packet, done_tun=1 and done_tok=0 if fifo_cnt was 0 during sending while fewer than the packet length of bytes had been read. Otherwise done_tun=0 and done_tok=1.
- R9: An underrun does not withdraw tx_start. The MAC keeps reading as bytes arrive, and the packet still ends with a done pulse.
- R10: pkt_begin while a packet is in flight is ignored. The threshold and counters of the current packet are kept.
- R11: done_valid is a one-cycle pulse in the cycle after mac_eop is seen while tx_start is 1. mac_eop at any other time is ignored.
- R12: pkt_loaded becomes 1 once the number of wr_en strobes since pkt_begin reaches the captured length. It stays 1 while the FIFO drains, until the next packet begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_begin | input | 1 | Descriptor handoff strobe, accepted only when idle |
| thr_code | input | 6 | Early-start threshold code |
| pkt_len | input | 13 | Packet length in bytes (1 or more) |
| wr_en | input | 1 | One byte of the packet written into the FIFO |
| rd_en | input | 1 | MAC takes one byte from the FIFO |
| fifo_cnt | input | 12 | Current FIFO occupancy in bytes |
| mac_eop | input | 1 | MAC end-of-packet strobe |
| tx_start | output | 1 | Permission for the MAC to drain the packet |
| pkt_loaded | output | 1 | Every byte of the packet has been written |
| done_valid | output | 1 | End-of-packet result pulse |
| done_tok | output | 1 | Packet sent without underrun |
| done_tun | output | 1 | FIFO ran dry during the packet |

## Verification
The hardest case to reach is an underrun followed by a normal completion. It needs the start to come from a low threshold, then the MAC has to overtake the filler, and then the filler has to resume. The bench starts a 16-byte packet with code 0 and writes 8 bytes. It then reads all 8 bytes to empty the FIFO, checks that permission is still held, and writes and reads the remaining 8 bytes before signalling end of packet. The clamp cannot occur at the default capacity, so a second instance with a 512-byte FIFO checks it.

// File: rtl/etg_pkg.sv
package etg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2
  } etg_state_e;
endpackage

// File: rtl/etg_thr_decode.sv
module etg_thr_decode #(
  parameter int CODE_W     = 6,
  parameter int BASE_BYTES = 8,
  parameter int UNIT_BYTES = 32,
  parameter int FIFO_BYTES = 2048,
  parameter int THR_W      = $clog2(FIFO_BYTES) + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [THR_W-1:0]  thr
);
  localparam int RAW_W   = CODE_W + $clog2(UNIT_BYTES) + 1;
  localparam int CMP_W   = ((RAW_W > THR_W) ? RAW_W : THR_W) + 1;
  localparam int MAX_RAW = ((1 << CODE_W) - 1) * UNIT_BYTES;

  logic [CMP_W-1:0] raw;

  always_comb begin
    if (code == '0) raw = CMP_W'(BASE_BYTES);
    else            raw = CMP_W'(code) * CMP_W'(UNIT_BYTES);
  end

  generate
    if (MAX_RAW > FIFO_BYTES || BASE_BYTES > FIFO_BYTES) begin : g_clamp
      always_comb begin
        if (raw > CMP_W'(FIFO_BYTES)) thr = THR_W'(FIFO_BYTES);
        else                          thr = THR_W'(raw);
      end
    end else begin : g_pass
      assign thr = THR_W'(raw);
    end
  endgenerate
endmodule

// File: rtl/etg_counters.sv
module etg_counters #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic             busy,
  input  logic             wr_en,
  input  logic             rd_ok,
  input  logic [LEN_W-1:0] len_q,
  output logic             loaded,
  output logic             rd_short
);
  logic [LEN_W-1:0] wr_cnt_q, wr_cnt_d;
  logic [LEN_W-1:0] rd_cnt_q, rd_cnt_d;
  logic             wr_ce, rd_ce;

  assign loaded   = busy && (wr_cnt_q >= len_q);
  assign rd_short = rd_cnt_q < len_q;

  always_comb begin
    wr_ce    = clr || (busy && wr_en && !loaded);
    rd_ce    = clr || (rd_ok && rd_short);
    wr_cnt_d = clr ? '0 : wr_cnt_q + LEN_W'(1);
    rd_cnt_d = clr ? '0 : rd_cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
    end else begin
      if (wr_ce) wr_cnt_q <= wr_cnt_d;
      if (rd_ce) rd_cnt_q <= rd_cnt_d;
    end
  end

  // R12
  loaded_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (loaded && !clr && busy) |=> (loaded || !busy));
endmodule

// File: rtl/etg_ctrl.sv
module etg_ctrl
  import etg_pkg::*;
#(
  parameter int LEN_W      = 13,
  parameter int CNT_W      = 12,
  parameter int FIFO_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             pkt_begin,
  input  logic [CNT_W-1:0] thr,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic             mac_eop,
  input  logic             loaded,
  input  logic             rd_short,
  output logic             begin_ok,
  output logic             busy,
  output logic             sending,
  output logic [LEN_W-1:0] len_q,
  output logic             done_valid,
  output logic             done_tok,
  output logic             done_tun
);
  etg_state_e       state_q, state_d;
  logic [CNT_W-1:0] thr_q;
  logic             tun_q, tun_d, dry_now, end_now;
  logic             dv_d;

  assign busy     = (state_q != ST_IDLE);
  assign sending  = (state_q == ST_SEND);
  assign begin_ok = pkt_begin && (state_q == ST_IDLE);
  assign dry_now  = sending && (fifo_cnt == '0) && rd_short;
  assign end_now  = sending && mac_eop;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (pkt_begin) state_d = ST_FILL;
      ST_FILL: if ((fifo_cnt >= thr_q) || loaded) state_d = ST_SEND;
      ST_SEND: if (mac_eop) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    tun_d = begin_ok ? 1'b0 : (tun_q || dry_now);
    dv_d  = end_now;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      thr_q      <= '0;
      len_q      <= '0;
      tun_q      <= 1'b0;
      done_valid <= 1'b0;
      done_tok   <= 1'b0;
      done_tun   <= 1'b0;
    end else begin
      state_q    <= state_d;
      tun_q      <= tun_d;
      done_valid <= dv_d;
      if (begin_ok) begin
        thr_q <= thr;
        len_q <= pkt_len;
      end
      if (end_now) begin
        done_tun <= tun_d;
        done_tok <= !tun_d;
      end
    end
  end

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sending) |-> $past((fifo_cnt >= thr_q) || loaded));
  // R4
  thr_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (thr_q <= CNT_W'(FIFO_BYTES)) && (thr_q != '0));
  // R6
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (sending && !mac_eop) |=> sending);
  // R7
  thr_latch_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> ($stable(thr_q) && $stable(len_q)));
  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_valid |-> (done_tok != done_tun));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_valid |-> ($past(mac_eop) && !sending));
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_valid |=> !done_valid);
endmodule

// File: rtl/tx_early_gate.sv
module tx_early_gate #(
  parameter int FIFO_BYTES = 2048,
  parameter int CODE_W     = 6,
  parameter int LEN_W      = 13,
  parameter int BASE_BYTES = 8,
  parameter int UNIT_BYTES = 32,
  parameter int CNT_W      = $clog2(FIFO_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_begin,
  input  logic [CODE_W-1:0] thr_code,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic              mac_eop,
  output logic              tx_start,
  output logic              pkt_loaded,
  output logic              done_valid,
  output logic              done_tok,
  output logic              done_tun
);
  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic [CNT_W-1:0] thr;
  logic             begin_ok, busy, sending, loaded, rd_short, rd_ok;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  etg_thr_decode #(
    .CODE_W(CODE_W), .BASE_BYTES(BASE_BYTES), .UNIT_BYTES(UNIT_BYTES),
    .FIFO_BYTES(FIFO_BYTES), .THR_W(CNT_W)
  ) u_dec (
    .code(thr_code),
    .thr (thr)
  );

  etg_ctrl #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .FIFO_BYTES(FIFO_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_ni    (rst_i),
    .pkt_begin (pkt_begin),
    .thr       (thr),
    .pkt_len   (pkt_len),
    .fifo_cnt  (fifo_cnt),
    .mac_eop   (mac_eop),
    .loaded    (loaded),
    .rd_short  (rd_short),
    .begin_ok  (begin_ok),
    .busy      (busy),
    .sending   (sending),
    .len_q     (len_q),
    .done_valid(done_valid),
    .done_tok  (done_tok),
    .done_tun  (done_tun)
  );

  assign rd_ok = sending && rd_en && (fifo_cnt != '0);

  etg_counters #(
    .LEN_W(LEN_W)
  ) u_cnt (
    .clk     (clk),
    .rst_ni  (rst_i),
    .clr     (begin_ok),
    .busy    (busy),
    .wr_en   (wr_en),
    .rd_ok   (rd_ok),
    .len_q   (len_q),
    .loaded  (loaded),
    .rd_short(rd_short)
  );

  assign tx_start   = sending;
  assign pkt_loaded = loaded;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rst_i) |-> (!tx_start && !done_valid));
endmodule

// File: tb/tx_early_gate_test.sv
module tx_early_gate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_begin, s_begin;
  logic [5:0]  thr_code;
  logic [12:0] pkt_len;
  logic        wr_en, rd_en, mac_eop;
  logic [11:0] fifo_cnt;
  logic [9:0]  s_fifo;
  logic        tx_start, pkt_loaded, done_valid, done_tok, done_tun;
  logic        s_start, s_loaded, s_dv, s_tok, s_tun;
  int          n_checks = 0;
  int          n_errors = 0;

  always #10 clk = ~clk;

  tx_early_gate uut (
    .clk(clk), .rst_n(rst_n), .pkt_begin(pkt_begin), .thr_code(thr_code),
    .pkt_len(pkt_len), .wr_en(wr_en), .rd_en(rd_en), .fifo_cnt(fifo_cnt),
    .mac_eop(mac_eop), .tx_start(tx_start), .pkt_loaded(pkt_loaded),
    .done_valid(done_valid), .done_tok(done_tok), .done_tun(done_tun)
  );

  tx_early_gate #(.FIFO_BYTES(512)) uut_s (
    .clk(clk), .rst_n(rst_n), .pkt_begin(s_begin), .thr_code(thr_code),
    .pkt_len(pkt_len), .wr_en(wr_en), .rd_en(rd_en), .fifo_cnt(s_fifo),
    .mac_eop(mac_eop), .tx_start(s_start), .pkt_loaded(s_loaded),
    .done_valid(s_dv), .done_tok(s_tok), .done_tun(s_tun)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic begin_pkt(input logic [5:0] code, input logic [12:0] len);
    thr_code  = code;
    pkt_len   = len;
    pkt_begin = 1'b1;
    step();
    pkt_begin = 1'b0;
  endtask

  task automatic write_byte();
    wr_en = 1'b1;
    step();
    wr_en = 1'b0;
    fifo_cnt = fifo_cnt + 12'd1;
  endtask

  task automatic read_byte();
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    fifo_cnt = fifo_cnt - 12'd1;
  endtask

  task automatic finish_pkt(input string req, input int exp_tok, input int exp_tun);
    mac_eop = 1'b1;
    step();
    mac_eop = 1'b0;
    check({req, " done_valid pulse"}, done_valid, 1);
    check({req, " done_tok"}, done_tok, exp_tok);
    check({req, " done_tun"}, done_tun, exp_tun);
    check({req, " start released"}, tx_start, 0);
    step();
    check("R11 done_valid one cycle", done_valid, 0);
    fifo_cnt = '0;
  endtask

  task automatic t_reset();
    check("R1 tx_start", tx_start, 0);
    check("R1 pkt_loaded", pkt_loaded, 0);
    check("R1 done_valid", done_valid, 0);
  endtask

  task automatic t_code0();
    begin_pkt(6'd0, 13'd100);
    fifo_cnt = 12'd7;
    step();
    check("R2 below 8 bytes", tx_start, 0);
    fifo_cnt = 12'd8;
    step();
    check("R2 at 8 bytes", tx_start, 1);
    finish_pkt("R11", 1, 0);
  endtask

  task automatic t_code_n();
    begin_pkt(6'd2, 13'd200);
    fifo_cnt = 12'd63;
    step();
    check("R3 code 2 at 63", tx_start, 0);
    fifo_cnt = 12'd64;
    step();
    check("R3 code 2 at 64", tx_start, 1);
    fifo_cnt = 12'd10;
    step();
    step();
    check("R6 held below threshold", tx_start, 1);
    finish_pkt("R6", 1, 0);
  endtask

  task automatic t_clamp();
    thr_code = 6'd63;
    pkt_len  = 13'd1000;
    s_begin  = 1'b1;
    step();
    s_begin  = 1'b0;
    s_fifo   = 10'd511;
    step();
    check("R4 clamp at 511", s_start, 0);
    s_fifo = 10'd512;
    step();
    check("R4 clamp at 512", s_start, 1);
    mac_eop = 1'b1;
    step();
    mac_eop = 1'b0;
    check("R4 small instance done", s_dv, 1);
    s_fifo = '0;
    step();
  endtask

  task automatic t_loaded();
    begin_pkt(6'd2, 13'd20);
    for (int i = 0; i < 19; i++) write_byte();
    check("R12 19 of 20 written", pkt_loaded, 0);
    check("R5 not yet started", tx_start, 0);
    write_byte();
    check("R12 20 of 20 written", pkt_loaded, 1);
    step();
    check("R5 start on complete packet", tx_start, 1);
    for (int i = 0; i < 20; i++) read_byte();
    step();
    check("R12 loaded kept with empty FIFO", pkt_loaded, 1);
    finish_pkt("R8 clean", 1, 0);
  endtask

  task automatic t_underrun();
    begin_pkt(6'd0, 13'd16);
    for (int i = 0; i < 8; i++) write_byte();
    step();
    check("R2 started at 8 bytes", tx_start, 1);
    for (int i = 0; i < 8; i++) read_byte();
    step();
    check("R9 start held after FIFO empty", tx_start, 1);
    for (int i = 0; i < 8; i++) write_byte();
    for (int i = 0; i < 8; i++) read_byte();
    check("R9 still sending", tx_start, 1);
    finish_pkt("R8 underrun", 0, 1);
  endtask

  task automatic t_latch();
    begin_pkt(6'd2, 13'd40);
    thr_code = 6'd0;
    pkt_len  = 13'd5;
    for (int i = 0; i < 5; i++) write_byte();
    check("R7 length kept", pkt_loaded, 0);
    fifo_cnt = 12'd8;
    step();
    check("R7 threshold kept", tx_start, 0);
    fifo_cnt = 12'd64;
    step();
    check("R7 start at latched threshold", tx_start, 1);
    finish_pkt("R7", 1, 0);
  endtask

  task automatic t_busy();
    begin_pkt(6'd2, 13'd30);
    mac_eop = 1'b1;
    step();
    mac_eop = 1'b0;
    check("R11 eop while filling ignored", done_valid, 0);
    begin_pkt(6'd0, 13'd2);
    for (int i = 0; i < 2; i++) write_byte();
    check("R10 length not replaced", pkt_loaded, 0);
    fifo_cnt = 12'd8;
    step();
    check("R10 threshold not replaced", tx_start, 0);
    fifo_cnt = 12'd64;
    step();
    check("R10 start at first threshold", tx_start, 1);
    finish_pkt("R10", 1, 0);
  endtask

  initial begin
    #4_000_000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pkt_begin = 1'b0; s_begin = 1'b0;
    thr_code = '0; pkt_len = '0;
    wr_en = 1'b0; rd_en = 1'b0; mac_eop = 1'b0;
    fifo_cnt = '0; s_fifo = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_code0();
    t_code_n();
    t_clamp();
    t_loaded();
    t_underrun();
    t_latch();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule